// File: doc/BRIEF.md
# Synchronous Burst Pseudo-SRAM Controller

This block is the host side of a clocked burst link to a pseudo-SRAM. A client raises a request carrying direction, word address and two byte-lane enables. The controller acknowledges it and then runs one burst of four 16-bit words. The burst opens with a single-cycle address strobe (ADV) under an active chip select. The controller then counts a fixed initial latency and moves the data beats. For a write it drives four beats on consecutive clocks. For a read it accepts a beat only on clocks where the device's WAIT pin reports data available.

Two timing rules protect the device. First, chip select may stay low for only a limited number of clocks; this number is computed from the clock period and a time limit. If a read stalls for too long, the controller raises chip select and ends the burst. Second, after every burst chip select stays high for a configurable number of idle clocks before the next address strobe.

The state machine has six states. `ST_IDLE` waits for a request. `ST_ADDR` drives the address cycle. `ST_LAT` counts the remaining latency. `ST_WBEAT` and `ST_RBEAT` move the beats. `ST_GAP` holds the idle spacing. The transitions are:
- IDLE→ADDR when a request is acknowledged.
- ADDR→LAT always.
- LAT→WBEAT or LAT→RBEAT after LATENCY−1 clocks.
- WBEAT→GAP or RBEAT→GAP on the last beat.
- Any selected state→GAP when the time guard expires.
- GAP→IDLE after GAP_CYC clocks.

Top module: `psram_burst_ctrl`

## Requirements
- R1: While reset is held, mem_cs_n, mem_adv_n, mem_we_n, mem_oe_n, mem_lb_n and mem_ub_n are 1, and mem_dq_oe, wr_take, rd_valid and req_ack are 0.
- R2: The cycle after req_ack is the address cycle. In it mem_adv_n and mem_cs_n are 0 and mem_addr equals the accepted address. mem_adv_n is 0 in that one cycle only.
- R3: For a write, mem_we_n is 0 in the address cycle only, and mem_oe_n stays 1 for the whole burst. For a read, mem_we_n stays 1.
- R4: For a write, wr_take and mem_dq_oe are 1 in the four cycles numbered LATENCY to LATENCY+3, counting the address cycle as 0 (cycles 5 to 8 by default). In those cycles mem_dq_out equals wr_data.
- R5: For a read, mem_oe_n is 0 from cycle 1 until chip select rises, and mem_dq_oe stays 0.
- R6: For a read, from cycle LATENCY onward, rd_valid equals mem_wait (1 means data available) and rd_data equals mem_dq_in. The burst completes after exactly four such beats.
- R7: mem_wait has no effect while chip select is high or during cycles 1 to LATENCY−1: rd_valid stays 0 in those cycles.
- R8: While chip select is low, mem_lb_n equals the inverse of req_be[0] and mem_ub_n the inverse of req_be[1], as latched at acceptance. Both are 1 otherwise.
- R9: Chip select goes high in the cycle after the fourth beat.
- R10: Chip select is never low for more than BURST_LIMIT_NS/CLK_PERIOD_NS−1 consecutive cycles (124 by default). A stalled read is ended at exactly that count with no rd_valid.
- R11: After chip select rises, it stays high for at least GAP_CYC cycles (default 2) before the next address cycle. req_ack stays 0 during those cycles.
- R12: req_ack is 1 only while the controller is idle with req_valid high, so only one burst is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and device clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client request present |
| req_ack | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = burst write, 0 = burst read |
| req_addr | input | ADDR_W | Starting word address |
| req_be | input | 2 | Byte-lane enables, bit 0 low byte, bit 1 high byte |
| wr_data | input | DATA_W | Current write beat, consumed when wr_take is 1 |
| wr_take | output | 1 | Write beat taken this cycle |
| rd_valid | output | 1 | Read beat valid this cycle |
| rd_data | output | DATA_W | Read beat |
| mem_adv_n | output | 1 | Address strobe, active low |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Low byte enable, active low |
| mem_ub_n | output | 1 | High byte enable, active low |
| mem_addr | output | ADDR_W | Device address |
| mem_dq_out | output | DATA_W | Data toward the device |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data from the device |
| mem_wait | input | 1 | Device ready, 1 = data available |

## Verification
The end of the latency count and the WAIT qualification can fall in the same cycle. The device raises WAIT one clock early, and the last latency cycle and the first beat cycle sit next to each other. The bench drives WAIT high in cycles 3 and 4 of every read and checks that rd_valid stays 0 until cycle 5. It then drives WAIT with stall patterns that start on cycle 5 either low or high, and checks that exactly four beats are taken and that chip select rises on the next cycle. A second pairing is the time guard against the stall itself: WAIT is held low for the whole read, and chip select must rise at the guard count with no beat.

// File: rtl/psram_burst_pkg.sv
package psram_burst_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_LAT,
        ST_WBEAT,
        ST_RBEAT,
        ST_GAP
    } burst_state_t;
endpackage

// File: rtl/psram_span_counter.sv
module psram_span_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + W'(1);
        end
    end
endmodule

// File: rtl/psram_req_latch.sv
module psram_req_latch #(
    parameter int ADDR_W = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              in_write,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [1:0]        in_be,
    output logic              hold_write,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [1:0]        hold_be
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_write <= 1'b0;
            hold_addr  <= '0;
            hold_be    <= '0;
        end else if (load) begin
            hold_write <= in_write;
            hold_addr  <= in_addr;
            hold_be    <= in_be;
        end
    end
endmodule

// File: rtl/psram_burst_ctrl.sv
module psram_burst_ctrl
    import psram_burst_pkg::*;
#(
    parameter int ADDR_W         = 23,
    parameter int DATA_W         = 16,
    parameter int LATENCY        = 5,
    parameter int BURST_LEN      = 4,
    parameter int GAP_CYC        = 2,
    parameter int CLK_PERIOD_NS  = 20,
    parameter int BURST_LIMIT_NS = 2500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ack,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_be,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_take,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_adv_n,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    input  logic              mem_wait
);
    localparam int MAX_CS_LOW = BURST_LIMIT_NS / CLK_PERIOD_NS - 1;
    localparam int GUARD_W    = $clog2(MAX_CS_LOW + 1);
    localparam int PH_MAX     = (LATENCY > GAP_CYC) ? LATENCY : GAP_CYC;
    localparam int PH_W       = $clog2(PH_MAX + 1);
    localparam int BEAT_W     = $clog2(BURST_LEN + 1);

    burst_state_t state_q, state_d;

    logic              hold_write;
    logic [ADDR_W-1:0] hold_addr;
    logic [1:0]        hold_be;
    logic [PH_W-1:0]   phase_cnt;
    logic [BEAT_W-1:0] beat_cnt;
    logic [GUARD_W-1:0] guard_cnt;

    logic accept, cs_active, beat_take, last_beat, guard_hit;

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign cs_active = (state_q == ST_ADDR) || (state_q == ST_LAT) ||
                       (state_q == ST_WBEAT) || (state_q == ST_RBEAT);
    assign beat_take = (state_q == ST_WBEAT) || ((state_q == ST_RBEAT) && mem_wait);
    assign last_beat = beat_take && (beat_cnt == BEAT_W'(BURST_LEN - 1));
    assign guard_hit = cs_active && (guard_cnt == GUARD_W'(MAX_CS_LOW - 1));

    psram_req_latch #(.ADDR_W(ADDR_W)) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .in_write  (req_write),
        .in_addr   (req_addr),
        .in_be     (req_be),
        .hold_write(hold_write),
        .hold_addr (hold_addr),
        .hold_be   (hold_be)
    );

    // Phase counter restarts on every state change: latency and gap spans.
    psram_span_counter #(.W(PH_W)) u_phase (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state_q != state_d),
        .inc  (1'b1),
        .count(phase_cnt)
    );

    psram_span_counter #(.W(BEAT_W)) u_beat (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state_q == ST_ADDR),
        .inc  (beat_take),
        .count(beat_cnt)
    );

    // Counts cycles with chip select low; bounds the burst duration.
    psram_span_counter #(.W(GUARD_W)) u_guard (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!cs_active),
        .inc  (cs_active),
        .count(guard_cnt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_ADDR;
            ST_ADDR:  state_d = ST_LAT;
            ST_LAT:   if (phase_cnt == PH_W'(LATENCY - 2))
                          state_d = hold_write ? ST_WBEAT : ST_RBEAT;
            ST_WBEAT: if (last_beat) state_d = ST_GAP;
            ST_RBEAT: if (last_beat) state_d = ST_GAP;
            ST_GAP:   if (phase_cnt == PH_W'(GAP_CYC - 1)) state_d = ST_IDLE;
        endcase
        if (guard_hit) state_d = ST_GAP;
    end

    always_comb begin
        req_ack    = 1'b0;
        wr_take    = 1'b0;
        rd_valid   = 1'b0;
        mem_adv_n  = 1'b1;
        mem_cs_n   = 1'b1;
        mem_we_n   = 1'b1;
        mem_oe_n   = 1'b1;
        mem_dq_oe  = 1'b0;
        mem_dq_out = '0;
        unique case (state_q)
            ST_IDLE: req_ack = req_valid;
            ST_ADDR: begin
                mem_cs_n  = 1'b0;
                mem_adv_n = 1'b0;
                mem_we_n  = !hold_write;
            end
            ST_LAT: begin
                mem_cs_n = 1'b0;
                mem_oe_n = hold_write;
            end
            ST_WBEAT: begin
                mem_cs_n   = 1'b0;
                mem_dq_oe  = 1'b1;
                wr_take    = 1'b1;
                mem_dq_out = wr_data;
            end
            ST_RBEAT: begin
                mem_cs_n = 1'b0;
                mem_oe_n = 1'b0;
                rd_valid = mem_wait;
            end
            ST_GAP: ;
        endcase
        mem_lb_n = !(cs_active && hold_be[0]);
        mem_ub_n = !(cs_active && hold_be[1]);
        mem_addr = hold_addr;
        rd_data  = mem_dq_in;
    end
endmodule

// File: rtl/psram_burst_ctrl_sva.sv
module psram_burst_ctrl_sva #(
    parameter int GAP_CYC        = 2,
    parameter int CLK_PERIOD_NS  = 20,
    parameter int BURST_LIMIT_NS = 2500
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ack,
    input logic wr_take,
    input logic rd_valid,
    input logic mem_adv_n,
    input logic mem_cs_n,
    input logic mem_we_n,
    input logic mem_oe_n,
    input logic mem_dq_oe
);
    localparam int MAX_CS_LOW = BURST_LIMIT_NS / CLK_PERIOD_NS - 1;
    localparam int LOW_W      = $clog2(MAX_CS_LOW + 2);
    localparam int HIGH_W     = $clog2(GAP_CYC + 2);

    logic [LOW_W-1:0]  low_run;
    logic [HIGH_W-1:0] high_run;
    logic              seen_low;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run  <= '0;
            high_run <= '0;
            seen_low <= 1'b0;
        end else if (!mem_cs_n) begin
            if (low_run != LOW_W'(MAX_CS_LOW + 1)) low_run <= low_run + LOW_W'(1);
            high_run <= '0;
            seen_low <= 1'b1;
        end else begin
            low_run <= '0;
            if (high_run != HIGH_W'(GAP_CYC)) high_run <= high_run + HIGH_W'(1);
        end
    end

    AST_ADV_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) !mem_adv_n |=> mem_adv_n);              // R2
    AST_ADV_WITH_CS:  assert property (@(posedge clk) disable iff (!rst_n) !mem_adv_n |-> !mem_cs_n);              // R2
    AST_WE_ADDR_ONLY: assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> (mem_oe_n && !mem_adv_n)); // R3
    AST_DRIVE_EXCL:   assert property (@(posedge clk) disable iff (!rst_n) mem_dq_oe |-> (mem_oe_n && !mem_cs_n));  // R5
    AST_RDV_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> (!mem_cs_n && !mem_oe_n)); // R6
    AST_WAIT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) mem_cs_n |-> (!rd_valid && !wr_take));  // R7
    AST_CS_LIMIT:     assert property (@(posedge clk) disable iff (!rst_n) !mem_cs_n |-> (low_run < LOW_W'(MAX_CS_LOW))); // R10
    AST_GAP_HELD:     assert property (@(posedge clk) disable iff (!rst_n) (seen_low && $fell(mem_cs_n)) |-> (high_run >= HIGH_W'(GAP_CYC))); // R11
    AST_ACK_IDLE:     assert property (@(posedge clk) disable iff (!rst_n) req_ack |-> (mem_cs_n && req_valid));   // R12
endmodule

bind psram_burst_ctrl psram_burst_ctrl_sva #(
    .GAP_CYC       (GAP_CYC),
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .BURST_LIMIT_NS(BURST_LIMIT_NS)
) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ack  (req_ack),
    .wr_take  (wr_take),
    .rd_valid (rd_valid),
    .mem_adv_n(mem_adv_n),
    .mem_cs_n (mem_cs_n),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/psram_burst_ctrl_test.sv
module psram_burst_ctrl_test;
    localparam int ADDR_W  = 23;
    localparam int DATA_W  = 16;
    localparam int LAT     = 5;
    localparam int GAP     = 2;
    localparam int MAX_LOW = 2500 / 20 - 1;

    typedef struct packed {
        logic        wr;
        logic [1:0]  be;
        logic [15:0] addr;
        logic [7:0]  wmask;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'b11, 16'h0123, 8'hFF},
        '{1'b0, 2'b11, 16'h4560, 8'hFF},
        '{1'b0, 2'b01, 16'h0A0A, 8'b1101_0110},
        '{1'b1, 2'b10, 16'hFFFF, 8'hFF},
        '{1'b0, 2'b10, 16'h7001, 8'b1111_0000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, mem_wait = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_be = '0;
    logic [DATA_W-1:0] wr_data = '0, mem_dq_in = '0;
    logic req_ack, wr_take, rd_valid, mem_adv_n, mem_cs_n, mem_we_n, mem_oe_n;
    logic mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [DATA_W-1:0] rd_data, mem_dq_out;
    logic [ADDR_W-1:0] mem_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    psram_burst_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ack(req_ack),
        .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
        .wr_data(wr_data), .wr_take(wr_take), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_adv_n(mem_adv_n), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_wait(mem_wait)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic step();
        @(negedge clk);
        #2;
    endtask

    task automatic chk_lanes(input logic [1:0] be);
        chk("R8 lb_n", mem_lb_n, !be[0]);
        chk("R8 ub_n", mem_ub_n, !be[1]);
    endtask

    // Raise a request and wait for acknowledge; ends inside the address cycle.
    task automatic issue(input logic wr, input logic [1:0] be, input logic [15:0] addr, input int exp_wait);
        int waits = 0;
        req_valid = 1'b1;
        req_write = wr;
        req_be    = be;
        req_addr  = ADDR_W'(addr);
        #1;
        while (!req_ack && waits < 20) begin
            chk("R11 cs high in gap", mem_cs_n, 1'b1);
            step();
            waits++;
        end
        chk("R11/R12 ack delay", waits, exp_wait);
        step();
        chk("R12 no ack in burst", req_ack, 1'b0);
        req_valid = 1'b0;
        chk("R2 adv low", mem_adv_n, 1'b0);
        chk("R2 cs low", mem_cs_n, 1'b0);
        chk("R2 addr", mem_addr, ADDR_W'(addr));
        chk("R3 we in addr cycle", mem_we_n, !wr);
        chk("R3 oe high in addr cycle", mem_oe_n, 1'b1);
        chk_lanes(be);
    endtask

    task automatic run_burst(input vec_t v, input int exp_wait);
        int beats = 0;
        int k = 1;
        issue(v.wr, v.be, v.addr, exp_wait);
        if (v.wr) begin
            for (int c = 1; c <= LAT + 3; c++) begin
                @(negedge clk);
                wr_data = 16'hA000 ^ {v.addr[7:0], 8'(c)};
                mem_wait = c[0];
                #2;
                chk("R2 adv single", mem_adv_n, 1'b1);
                chk("R3 we high", mem_we_n, 1'b1);
                chk("R3 oe high", mem_oe_n, 1'b1);
                chk("R4 cs low", mem_cs_n, 1'b0);
                chk("R4 wr_take", wr_take, c >= LAT);
                chk("R4 dq_oe", mem_dq_oe, c >= LAT);
                if (c >= LAT) chk("R4 dq_out", mem_dq_out, wr_data);
                chk_lanes(v.be);
            end
        end else begin
            for (int c = 1; c < LAT; c++) begin
                @(negedge clk);
                mem_wait = (c >= LAT - 2);
                mem_dq_in = 16'hB000 + 16'(c);
                #2;
                chk("R7 no valid in latency", rd_valid, 1'b0);
                chk("R5 oe low", mem_oe_n, 1'b0);
                chk("R5 no drive", mem_dq_oe, 1'b0);
                chk("R3 we high on read", mem_we_n, 1'b1);
                chk_lanes(v.be);
            end
            k = LAT;
            while (beats < 4 && k < LAT + 20) begin
                logic w;
                @(negedge clk);
                w = (k - LAT < 8) ? v.wmask[k - LAT] : 1'b1;
                mem_wait = w;
                mem_dq_in = 16'hC000 + 16'(k);
                #2;
                chk("R6 rd_valid follows wait", rd_valid, w);
                if (w) chk("R6 rd_data", rd_data, 16'hC000 + 16'(k));
                chk("R5 oe low", mem_oe_n, 1'b0);
                chk("R6 cs low", mem_cs_n, 1'b0);
                beats += int'(w);
                k++;
            end
        end
        @(negedge clk);
        mem_wait = 1'b1;
        #2;
        chk("R9 cs rises after last beat", mem_cs_n, 1'b1);
        chk("R7 no valid with cs high", rd_valid, 1'b0);
        chk("R9 no take after burst", wr_take, 1'b0);
        chk("R8 lb off", mem_lb_n, 1'b1);
        chk("R8 ub off", mem_ub_n, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R1 cs_n", mem_cs_n, 1'b1);
        chk("R1 adv_n", mem_adv_n, 1'b1);
        chk("R1 we_n", mem_we_n, 1'b1);
        chk("R1 oe_n", mem_oe_n, 1'b1);
        chk("R1 lanes", {mem_lb_n, mem_ub_n}, 2'b11);
        chk("R1 idle strobes", {mem_dq_oe, wr_take, rd_valid, req_ack}, 4'b0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step();
            mem_wait = i[0];
            #1;
            chk("R7 wait ignored while idle", rd_valid, 1'b0);
            chk("R7 cs stays high", mem_cs_n, 1'b1);
        end

        for (int n = 0; n < NV; n++) begin
            run_burst(VECS[n], (n == 0) ? 0 : GAP);
        end

        begin
            int low = 1;
            logic done = 1'b0;
            mem_wait = 1'b0;
            issue(1'b0, 2'b11, 16'h3333, GAP);
            while (!done && low < 400) begin
                @(negedge clk);
                mem_wait = 1'b0;
                #2;
                if (mem_cs_n) done = 1'b1;
                else begin
                    low++;
                    chk("R10 no beat while stalled", rd_valid, 1'b0);
                end
            end
            chk("R10 cs low span at limit", low, MAX_LOW);
        end

        run_burst(VECS[0], GAP);
        run_burst(VECS[2], GAP);

        summary();
        $finish;
    end
endmodule